// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block keeps the interrupt cause byte and the interrupt enable byte of a packet network controller and drives one level-sensitive interrupt request. Datapath and allocator logic raise causes with single-cycle set pulses, and may withdraw them with clear pulses. Two causes are not pulsed. The transmit-queue-empty cause and the transmit-completion cause are ORed in from queue occupancy flags on every clock. Because of this, they return at once while their condition lasts.

The host reads the cause and enable bytes directly. It writes the enable byte, and it writes an acknowledge byte whose bits clear causes. Only a fixed subset of causes can be cleared this way. An acknowledge that has the transmit-completion bit set also asks the external completion queue to drop its head entry. The block gives that request as a one-cycle pulse.

Top module: `pkt_irq_status`

## Requirements
- R1: After reset the cause byte is 0x04 (transmit-queue-empty only), the enable byte is 0x00, and both the interrupt line and the pop pulse are low.
- R2: Cause bits sit at these positions: bit 6 early receive, bit 4 receive overrun, bit 3 allocation done, bit 2 transmit queue empty, bit 1 transmit complete, bit 0 receive. A set pulse on bit 6, 4, 3 or 0 sets that cause at the next clock edge. Set pulses on bits 7, 5, 2 and 1 have no effect, and cause bits 7 and 5 always read zero.
- R3: While tx_queue_empty_i is high, cause bit 2 reads 1 after the next edge. It stays set after the flag drops, until it is cleared.
- R4: While txdone_nonempty_i is high, cause bit 1 reads 1 after the next edge. It stays set after the flag drops, until it is cleared.
- R5: An acknowledge write with value V clears the cause bits in V AND 0xD6 at the next edge. Bits 0 and 3 are never cleared by an acknowledge. They are cleared only by clear pulses on evt_clr_i bits 0 and 3 (mask 0x59 applies to clear pulses).
- R6: Acknowledging bit 2 or bit 1 while its queue flag is still asserted leaves the bit set.
- R7: When a set pulse and an acknowledge or clear pulse hit the same bit in the same cycle, the bit ends up set.
- R8: A mask write stores the written byte, and it is readable on mask_o after the next edge.
- R9: irq_o is high exactly when (status_o AND mask_o) is non-zero, in every cycle.
- R10: An acknowledge write with bit 1 set gives txdone_pop_o high for exactly the cycle after the write, whatever the cause state. No other stimulus raises txdone_pop_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 8 | Cause set pulses, one per bit position |
| evt_clr_i | input | 8 | Cause clear pulses from the datapath (bits 0, 3, 4, 6 honoured) |
| tx_queue_empty_i | input | 1 | Transmit queue holds no entries |
| txdone_nonempty_i | input | 1 | Transmit completion queue holds entries |
| mask_wr_en_i | input | 1 | Host write strobe for the enable byte |
| mask_wr_data_i | input | 8 | Enable byte value |
| ack_wr_en_i | input | 1 | Host write strobe for the acknowledge byte |
| ack_wr_data_i | input | 8 | Acknowledge byte value |
| status_o | output | 8 | Cause byte |
| mask_o | output | 8 | Enable byte |
| irq_o | output | 1 | Interrupt request, level |
| txdone_pop_o | output | 1 | Request to drop the completion queue head |

## Verification
The bench builds the unit with its default 8-bit cause byte, acknowledge mask 0xD6 and event mask 0x59. At this width, every acknowledge value and every enable value can be applied in turn. Each of the 256 acknowledge values is applied to a fully set cause byte. Each of the 256 enable values is swept against fixed cause patterns. A long pseudo-random run then mixes set, clear, acknowledge and queue-flag stimulus in the same cycle. That run is where the set-over-clear priority and the re-forcing of the queue-derived bits are exercised.

// File: rtl/pis_pkg.sv
package pis_pkg;

    localparam int ST_W = 8;

    localparam int BIT_RX       = 0;
    localparam int BIT_TXDONE   = 1;
    localparam int BIT_TXEMPTY  = 2;
    localparam int BIT_ALLOC    = 3;
    localparam int BIT_OVERRUN  = 4;
    localparam int BIT_EARLY_RX = 6;

    typedef logic [ST_W-1:0] irq_byte_t;

    localparam irq_byte_t RESET_STATUS = irq_byte_t'(1) << BIT_TXEMPTY;

    typedef struct packed {
        irq_byte_t status;
        irq_byte_t mask;
        logic      irq;
        logic      pop;
    } pis_state_t;

endpackage

// File: rtl/pis_ack_decode.sv
module pis_ack_decode
    import pis_pkg::*;
#(
    parameter irq_byte_t ACK_MASK = 8'hD6
) (
    input  logic      ack_en,
    input  irq_byte_t ack_data,
    output irq_byte_t ack_clr,
    output logic      pop_req
);

    always_comb begin
        ack_clr = ack_en ? (ack_data & ACK_MASK) : '0;
        pop_req = ack_en & ack_data[BIT_TXDONE];
    end

endmodule

// File: rtl/pis_status_next.sv
module pis_status_next
    import pis_pkg::*;
#(
    parameter irq_byte_t EVT_MASK = 8'h59
) (
    input  irq_byte_t status_q,
    input  irq_byte_t evt_set,
    input  irq_byte_t evt_clr,
    input  irq_byte_t ack_clr,
    input  logic      txq_empty,
    input  logic      txdone_nonempty,
    output irq_byte_t status_d
);

    irq_byte_t forced;
    irq_byte_t set_vec;
    irq_byte_t clr_vec;

    always_comb begin
        forced                = '0;
        forced[BIT_TXEMPTY]   = txq_empty;
        forced[BIT_TXDONE]    = txdone_nonempty;
        set_vec               = (evt_set & EVT_MASK) | forced;
        clr_vec               = (evt_clr & EVT_MASK) | ack_clr;
        // set has priority over any clear in the same cycle
        status_d              = (status_q & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/pkt_irq_status.sv
module pkt_irq_status
    import pis_pkg::*;
#(
    parameter irq_byte_t ACK_MASK = 8'hD6,
    parameter irq_byte_t EVT_MASK = 8'h59
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] evt_set_i,
    input  logic [ST_W-1:0] evt_clr_i,
    input  logic            tx_queue_empty_i,
    input  logic            txdone_nonempty_i,
    input  logic            mask_wr_en_i,
    input  logic [ST_W-1:0] mask_wr_data_i,
    input  logic            ack_wr_en_i,
    input  logic [ST_W-1:0] ack_wr_data_i,
    output logic [ST_W-1:0] status_o,
    output logic [ST_W-1:0] mask_o,
    output logic            irq_o,
    output logic            txdone_pop_o
);

    localparam pis_state_t RST_STATE = '{status: RESET_STATUS, mask: '0, irq: 1'b0, pop: 1'b0};

    pis_state_t st_d, st_q;
    irq_byte_t  ack_clr;
    logic       pop_req;
    irq_byte_t  status_nx;

    pis_ack_decode #(.ACK_MASK(ACK_MASK)) u_ack (
        .ack_en   (ack_wr_en_i),
        .ack_data (ack_wr_data_i),
        .ack_clr  (ack_clr),
        .pop_req  (pop_req)
    );

    pis_status_next #(.EVT_MASK(EVT_MASK)) u_next (
        .status_q        (st_q.status),
        .evt_set         (evt_set_i),
        .evt_clr         (evt_clr_i),
        .ack_clr         (ack_clr),
        .txq_empty       (tx_queue_empty_i),
        .txdone_nonempty (txdone_nonempty_i),
        .status_d        (status_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = status_nx;
        if (mask_wr_en_i) begin
            st_d.mask = mask_wr_data_i;
        end
        // line computed from next values so it lines up with the registered bytes
        st_d.irq    = |(st_d.status & st_d.mask);
        st_d.pop    = pop_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o     = st_q.status;
    assign mask_o       = st_q.mask;
    assign irq_o        = st_q.irq;
    assign txdone_pop_o = st_q.pop;

endmodule

// File: rtl/pis_checker.sv
module pis_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] evt_set_i,
    input logic [7:0] evt_clr_i,
    input logic       tx_queue_empty_i,
    input logic       txdone_nonempty_i,
    input logic       mask_wr_en_i,
    input logic [7:0] mask_wr_data_i,
    input logic       ack_wr_en_i,
    input logic [7:0] ack_wr_data_i,
    input logic [7:0] status_o,
    input logic [7:0] mask_o,
    input logic       irq_o,
    input logic       txdone_pop_o
);

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_o == 8'h04 && mask_o == 8'h00 && !irq_o && !txdone_pop_o));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[7] && !status_o[5]));

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set_i[4] |=> status_o[4]);

    assert_txempty_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_queue_empty_i |=> status_o[2]);

    assert_txdone_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txdone_nonempty_i |=> status_o[1]);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr_en_i && ack_wr_data_i[6] && !evt_set_i[6]) |=> !status_o[6]);

    assert_ack_cannot_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !evt_clr_i[0]) |=> status_o[0]);

    assert_forced_survives_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr_en_i && ack_wr_data_i[2] && tx_queue_empty_i) |=> status_o[2]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set_i[6] && (evt_clr_i[6] || ack_wr_en_i)) |=> status_o[6]);

    assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en_i |=> (mask_o == $past(mask_wr_data_i)));

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_o & mask_o));

    assert_pop_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr_en_i && ack_wr_data_i[1]) |=> txdone_pop_o);

    assert_pop_only_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_wr_en_i && ack_wr_data_i[1]) |=> !txdone_pop_o);

endmodule

bind pkt_irq_status pis_checker u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .evt_set_i         (evt_set_i),
    .evt_clr_i         (evt_clr_i),
    .tx_queue_empty_i  (tx_queue_empty_i),
    .txdone_nonempty_i (txdone_nonempty_i),
    .mask_wr_en_i      (mask_wr_en_i),
    .mask_wr_data_i    (mask_wr_data_i),
    .ack_wr_en_i       (ack_wr_en_i),
    .ack_wr_data_i     (ack_wr_data_i),
    .status_o          (status_o),
    .mask_o            (mask_o),
    .irq_o             (irq_o),
    .txdone_pop_o      (txdone_pop_o)
);

// File: tb/pkt_irq_status_test.sv
`timescale 1ns/1ps
module pkt_irq_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_set_i = '0;
    logic [7:0] evt_clr_i = '0;
    logic       tx_queue_empty_i = 1'b0;
    logic       txdone_nonempty_i = 1'b0;
    logic       mask_wr_en_i = 1'b0;
    logic [7:0] mask_wr_data_i = '0;
    logic       ack_wr_en_i = 1'b0;
    logic [7:0] ack_wr_data_i = '0;
    logic [7:0] status_o;
    logic [7:0] mask_o;
    logic       irq_o;
    logic       txdone_pop_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_st;
    logic [7:0] exp_mk;
    logic       exp_pop;

    always #5 clk = ~clk;

    pkt_irq_status uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .evt_set_i         (evt_set_i),
        .evt_clr_i         (evt_clr_i),
        .tx_queue_empty_i  (tx_queue_empty_i),
        .txdone_nonempty_i (txdone_nonempty_i),
        .mask_wr_en_i      (mask_wr_en_i),
        .mask_wr_data_i    (mask_wr_data_i),
        .ack_wr_en_i       (ack_wr_en_i),
        .ack_wr_data_i     (ack_wr_data_i),
        .status_o          (status_o),
        .mask_o            (mask_o),
        .irq_o             (irq_o),
        .txdone_pop_o      (txdone_pop_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " status"}, status_o, exp_st);
        chk({tag, " mask"}, mask_o, exp_mk);
        chk({"R9 ", tag, " irq"}, {7'd0, irq_o}, {7'd0, |(exp_st & exp_mk)});
        chk({"R10 ", tag, " pop"}, {7'd0, txdone_pop_o}, {7'd0, exp_pop});
    endtask

    // drive at a negedge, update the model, sample at the following negedge
    task automatic step(input string tag,
                        input logic [7:0] s, input logic [7:0] c,
                        input logic txe, input logic dne,
                        input logic mwe, input logic [7:0] md,
                        input logic awe, input logic [7:0] ad);
        logic [7:0] clr;
        logic [7:0] set;
        evt_set_i = s; evt_clr_i = c;
        tx_queue_empty_i = txe; txdone_nonempty_i = dne;
        mask_wr_en_i = mwe; mask_wr_data_i = md;
        ack_wr_en_i = awe; ack_wr_data_i = ad;
        clr = (c & 8'h59) | (awe ? (ad & 8'hD6) : 8'h00);
        set = (s & 8'h59) | {5'd0, txe, dne, 1'b0};
        exp_st = (exp_st & ~clr) | set;
        if (mwe) exp_mk = md;
        exp_pop = awe & ad[1];
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        exp_st = 8'h04; exp_mk = 8'h00; exp_pop = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // clear everything
        step("R5 clear all", 8'h00, 8'h59, 0, 0, 0, 8'h00, 1, 8'hFF);
        chk("R5 cleared", status_o, 8'h00);
        // R2 ignored set positions
        step("R2 ignored sets", 8'hA6, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
        chk("R2 ignored", status_o, 8'h00);
        step("R2 event sets", 8'h59, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
        chk("R2 sets", status_o, 8'h59);

        // R5 exhaustive acknowledge sweep on a full cause byte
        for (int v = 0; v < 256; v++) begin
            step("R5 preset", 8'h59, 8'h00, 1, 1, 0, 8'h00, 0, 8'h00);
            step("R5 ack sweep", 8'h00, 8'h00, 0, 0, 0, 8'h00, 1, v[7:0]);
        end

        // R3/R4 sticky after flags drop, R6 forced bits survive ack
        step("R5 clear", 8'h00, 8'h59, 0, 0, 0, 8'h00, 1, 8'hFF);
        step("R3 R4 force", 8'h00, 8'h00, 1, 1, 0, 8'h00, 0, 8'h00);
        chk("R3 R4 forced", status_o, 8'h06);
        step("R3 R4 sticky", 8'h00, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
        chk("R3 R4 sticky", status_o, 8'h06);
        step("R6 ack held", 8'h00, 8'h00, 1, 1, 0, 8'h00, 1, 8'h06);
        chk("R6 survive", status_o, 8'h06);
        chk("R10 pop on held ack", {7'd0, txdone_pop_o}, 8'h01);
        step("R6 ack released", 8'h00, 8'h00, 0, 0, 0, 8'h00, 1, 8'h06);
        chk("R6 cleared", status_o, 8'h00);

        // R7 set wins against ack and clear
        step("R7 set vs ack", 8'h50, 8'h50, 0, 0, 0, 8'h00, 1, 8'h50);
        chk("R7 set wins", status_o, 8'h50);
        step("R7 set vs clear", 8'h09, 8'h09, 0, 0, 0, 8'h00, 0, 8'h00);
        chk("R7 set wins clr", status_o, 8'h59);

        // R8/R9 mask sweeps against two cause patterns
        step("R5 to 0x40", 8'h00, 8'h19, 0, 0, 0, 8'h00, 0, 8'h00);
        chk("R5 pattern", status_o, 8'h40);
        for (int m = 0; m < 256; m++)
            step("R8 mask sweep A", 8'h00, 8'h00, 0, 0, 1, m[7:0], 0, 8'h00);
        step("R2 to 0x59", 8'h19, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
        for (int m = 0; m < 256; m++)
            step("R8 mask sweep B", 8'h00, 8'h00, 0, 0, 1, m[7:0], 0, 8'h00);

        // R10 pop regardless of cause state
        step("R10 pop empty", 8'h00, 8'h59, 0, 0, 0, 8'h00, 1, 8'hFF);
        step("R10 pop", 8'h00, 8'h00, 0, 0, 0, 8'h00, 1, 8'h02);
        chk("R10 pop high", {7'd0, txdone_pop_o}, 8'h01);
        step("R10 pop idle", 8'h00, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
        chk("R10 pop low", {7'd0, txdone_pop_o}, 8'h00);

        // mixed pseudo-random traffic
        lfsr = 32'hACE1_2357;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r = lfsr * 32'h9E37_79B1;
            step("R7 random", r[7:0] & r[15:8], r[23:16] & r[31:24],
                 r[3], r[9], r[27] & r[5], r[31:24], r[12] & r[20], r[23:16]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule